// File: doc/BRIEF.md
# Load Dependence and Stall-Delay Predictor

This block is a direct-mapped prediction table for a multithreaded fetch policy. Each entry is selected by bits of a load's program counter. An entry holds two things: a single bit that says whether the load is expected to wait for an older store whose address is still unknown, and an estimate in cycles of how long that wait will last. The fetch stage reads the table through a combinational lookup port. It can gate a thread when a dependence is predicted, then release the thread early, so that its instructions arrive just as the store address resolves.

A training port is driven once the real outcome of a load is known. It carries the load's PC, whether the load actually waited on a store address, and the measured wait. The delay estimate is learned in one of three selectable ways:
- keep the largest wait ever seen;
- keep the latest wait;
- keep the mean of the last four waits.

A synchronous clear empties the whole table.

Top module: `mdp_delay_table`

## Requirements
- R1: The entry index is `pc[PC_LSB+IDX_W-1:PC_LSB]` (bits 7:2 by default). Two PCs that differ only outside those bits share an entry.
- R2: The lookup port returns the addressed entry's prediction bit on `lu_pred` and its delay on `lu_delay` in the same cycle, with no register in between.
- R3: Reset (`rst_n` low) and a clock edge with `clr` high both set every prediction bit, delay and adaptive history sample to zero. `clr` takes priority over a training write in the same cycle.
- R4: A training write with `tr_dep`=1 sets the entry's prediction bit. The new value is visible from the next cycle.
- R5: A training write with `tr_dep`=0 clears the entry's prediction bit and leaves its delay and its history unchanged.
- R6: The measured wait is saturated to 255 (the largest 8-bit value) before it is used in any update.
- R7: With `mode`=0 (conservative), a dependent training write sets the delay to the larger of the stored delay and the saturated sample.
- R8: With `mode`=1 or `mode`=3 (aggressive), a dependent training write sets the delay to the saturated sample.
- R9: With `mode`=2 (adaptive), a dependent training write sets the delay to floor(sum/4) of the entry's last four saturated samples, the new one included. Samples not yet written since clear count as zero. Every dependent training write records its sample in the history, whatever the mode.
- R10: When a lookup and a training write address the same entry in the same cycle, the lookup returns the contents from before the write.
- R11: In a cycle with neither `tr_valid` nor `clr`, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the whole table |
| mode | input | 2 | Delay update policy: 0 max, 1/3 last, 2 average of four |
| lu_pc | input | 32 | Lookup load PC |
| lu_pred | output | 1 | Predicted dependence on an unresolved store |
| lu_delay | output | 8 | Predicted stall delay in cycles |
| tr_valid | input | 1 | Training write enable |
| tr_pc | input | 32 | Training load PC |
| tr_dep | input | 1 | Load actually waited on a store address |
| tr_wait | input | 12 | Measured wait in cycles |

## Verification
The embedded assertions check the following on every cycle, against the stored entries:
- clear empties the table;
- a dependent write sets the prediction bit;
- a non-dependent write clears the bit and keeps the delay;
- the conservative delay never decreases;
- the aggressive delay equals the saturated sample;
- idle cycles change nothing.

The four-sample average, the aliasing of PCs onto one entry, the read-before-write order on a same-index collision, and the history carried across mode switches depend on sequences of writes. Only the bench's directed and random scenarios show them, checked against its reference model.

// File: rtl/mdp_delay_table.sv
module mdp_delay_table #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int PC_LSB  = 2,
  parameter int DLY_W   = 8,
  parameter int WAIT_W  = 12,
  parameter int HIST_LG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        mode,
  input  logic [PC_W-1:0]   lu_pc,
  output logic              lu_pred,
  output logic [DLY_W-1:0]  lu_delay,
  input  logic              tr_valid,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic              tr_dep,
  input  logic [WAIT_W-1:0] tr_wait
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HIST  = 1 << HIST_LG;
  localparam int SUM_W = DLY_W + HIST_LG;
  localparam int DMAX  = (1 << DLY_W) - 1;

  logic             pred_q [DEPTH];
  logic [DLY_W-1:0] dly_q  [DEPTH];
  logic [DLY_W-1:0] hist_q [DEPTH][HIST];
  logic [SUM_W-1:0] sum_q  [DEPTH];

  logic [IDX_W-1:0] lu_idx, tr_idx;
  logic [DLY_W-1:0] sample, cur_dly, oldest, new_dly;
  logic [SUM_W-1:0] sum_nxt;

  assign lu_idx   = lu_pc[PC_LSB +: IDX_W];
  assign tr_idx   = tr_pc[PC_LSB +: IDX_W];
  assign lu_pred  = pred_q[lu_idx];
  assign lu_delay = dly_q[lu_idx];

  assign sample  = (tr_wait > WAIT_W'(DMAX)) ? DLY_W'(DMAX) : tr_wait[DLY_W-1:0];
  assign cur_dly = dly_q[tr_idx];
  assign oldest  = hist_q[tr_idx][HIST-1];
  assign sum_nxt = sum_q[tr_idx] - SUM_W'(oldest) + SUM_W'(sample);

  always_comb begin
    case (mode)
      2'd0:    new_dly = (sample > cur_dly) ? sample : cur_dly;
      2'd2:    new_dly = sum_nxt[SUM_W-1:HIST_LG];
      default: new_dly = sample;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pred_q[i] <= 1'b0;
        dly_q[i]  <= '0;
        sum_q[i]  <= '0;
        for (int k = 0; k < HIST; k++) hist_q[i][k] <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        pred_q[i] <= 1'b0;
        dly_q[i]  <= '0;
        sum_q[i]  <= '0;
        for (int k = 0; k < HIST; k++) hist_q[i][k] <= '0;
      end
    end else if (tr_valid) begin
      if (tr_dep) begin
        pred_q[tr_idx]    <= 1'b1;
        dly_q[tr_idx]     <= new_dly;
        sum_q[tr_idx]     <= sum_nxt;
        hist_q[tr_idx][0] <= sample;
        for (int k = 1; k < HIST; k++) hist_q[tr_idx][k] <= hist_q[tr_idx][k-1];
      end else begin
        pred_q[tr_idx] <= 1'b0;
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lu_pred == 1'b0 && lu_delay == '0)); // R3
  AST_DEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_dep && !clr) |=> pred_q[$past(tr_idx)]); // R4
  AST_NODEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_dep && !clr) |=>
      (!pred_q[$past(tr_idx)] && dly_q[$past(tr_idx)] == $past(cur_dly))); // R5
  AST_MAX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_dep && !clr && mode == 2'd0) |=>
      (dly_q[$past(tr_idx)] >= $past(cur_dly) && dly_q[$past(tr_idx)] >= $past(sample))); // R7
  AST_LAST_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_dep && !clr && mode[0]) |=>
      (dly_q[$past(tr_idx)] == ($past(tr_wait) > WAIT_W'(DMAX) ? DLY_W'(DMAX)
                                                               : $past(tr_wait[DLY_W-1:0])))); // R8 R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr_valid && !clr) |=>
      (dly_q[$past(lu_idx)] == $past(lu_delay) && pred_q[$past(lu_idx)] == $past(lu_pred))); // R11
endmodule

// File: tb/mdp_delay_table_tb_top.sv
`timescale 1ns/1ps
module mdp_delay_table_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        clr = 0;
  logic [1:0]  mode = 0;
  logic [31:0] lu_pc = 0, tr_pc = 0;
  logic        lu_pred;
  logic [7:0]  lu_delay;
  logic        tr_valid = 0, tr_dep = 0;
  logic [11:0] tr_wait = 0;

  int n_chk = 0, n_fail = 0;
  int ref_pred [64];
  int ref_dly  [64];
  int ref_hist [64][4];

  always #2.5 clk = ~clk;

  mdp_delay_table dut_i (.clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode),
    .lu_pc(lu_pc), .lu_pred(lu_pred), .lu_delay(lu_delay), .tr_valid(tr_valid),
    .tr_pc(tr_pc), .tr_dep(tr_dep), .tr_wait(tr_wait));

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic int sat(input int w);
    return (w > 255) ? 255 : w;
  endfunction

  function automatic int next_delay(input int m, input int i, input int s);
    int sum;
    sum = s + ref_hist[i][0] + ref_hist[i][1] + ref_hist[i][2];
    case (m)
      0:       return (s > ref_dly[i]) ? s : ref_dly[i];
      2:       return sum / 4;
      default: return s;
    endcase
  endfunction

  task automatic ref_clear();
    for (int i = 0; i < 64; i++) begin
      ref_pred[i] = 0; ref_dly[i] = 0;
      for (int k = 0; k < 4; k++) ref_hist[i][k] = 0;
    end
  endtask

  task automatic check(input string req);
    int i;
    i = idx_of(lu_pc);
    n_chk++;
    if (lu_pred !== ref_pred[i][0] || int'(lu_delay) != ref_dly[i]) begin
      n_fail++;
      $display("FAIL %s: idx %0d actual pred=%0b delay=%0d expected pred=%0d delay=%0d",
               req, i, lu_pred, lu_delay, ref_pred[i], ref_dly[i]);
    end
  endtask

  task automatic step(input logic [31:0] lpc, input logic tv, input logic [31:0] tpc,
                      input logic dep, input int w, input logic c, input int m, input string req);
    int i, s;
    lu_pc = lpc; tr_valid = tv; tr_pc = tpc; tr_dep = dep;
    tr_wait = 12'(w); clr = c; mode = 2'(m);
    #1 check(req);
    @(posedge clk);
    #0.1;
    i = idx_of(tpc); s = sat(w);
    if (c) ref_clear();
    else if (tv) begin
      if (dep) begin
        ref_pred[i] = 1;
        ref_dly[i] = next_delay(m, i, s);
        for (int k = 3; k > 0; k--) ref_hist[i][k] = ref_hist[i][k-1];
        ref_hist[i][0] = s;
      end else ref_pred[i] = 0;
    end
    @(negedge clk);
    tr_valid = 0; clr = 0;
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    look(32'h0000_0010, "R3 reset");
    rst_n = 1;
    @(negedge clk);
    look(32'h0000_00FC, "R3 reset");

    // R9 first adaptive sample averaged with zeros
    step(32'h40, 1, 32'h40, 1, 40, 0, 2, "R2");
    look(32'h40, "R9 first sample");
    for (int j = 0; j < 4; j++) step(32'h40, 1, 32'h40, 1, 20, 0, 2, "R9");
    look(32'h40, "R9 four samples");
    // R7 conservative keeps max
    step(32'h80, 1, 32'h80, 1, 50, 0, 0, "R4");
    step(32'h80, 1, 32'h80, 1, 30, 0, 0, "R4");
    look(32'h80, "R7 max kept");
    // R8 aggressive, mode 3 too
    step(32'h80, 1, 32'h80, 1, 12, 0, 1, "R8");
    look(32'h80, "R8 last");
    step(32'h80, 1, 32'h80, 1, 77, 0, 3, "R8");
    look(32'h80, "R8 mode3");
    // R6 saturation
    step(32'h84, 1, 32'h84, 1, 1000, 0, 1, "R6");
    look(32'h84, "R6 saturate");
    // R10 same cycle collision returns old contents
    step(32'h84, 1, 32'h84, 1, 5, 0, 1, "R10");
    look(32'h84, "R10 after");
    // R5 non-dependent clears bit keeps delay
    step(32'h84, 1, 32'h84, 0, 99, 0, 1, "R5");
    look(32'h84, "R5 cleared");
    // R1 aliasing through upper PC bits
    step(32'h0, 1, 32'hABC0_0088, 1, 33, 0, 1, "R1");
    look(32'h0000_0088, "R1 alias");
    look(32'h0000_0089, "R1 low bits");
    // R11 idle cycles
    look(32'h80, "R11 idle");
    // R3 clear wins over training
    step(32'h80, 1, 32'h80, 1, 200, 1, 1, "R3");
    look(32'h80, "R3 cleared");
    look(32'h40, "R3 cleared");

    process::self().srandom(32'd12345);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] tp, lp;
      tp = {$urandom, 2'b00} & 32'hFFFF_00FC;
      tp[7:6] = 2'b00;
      lp = ($urandom % 3 == 0) ? tp : ({$urandom} & 32'h0000_003C);
      step(lp, ($urandom % 4) != 0, tp, ($urandom % 5) != 0, int'($urandom % 400),
           ($urandom % 300) == 0, int'($urandom % 4), "R7/R8/R9/R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule